// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus with a 16-bit address and the two memories on a game cartridge: a banked program ROM and an optional battery-less external RAM. The CPU cannot write the ROM. Writes that land in the lower half of the address map therefore go to four small control registers instead. One register enables RAM. One holds a 5-bit low ROM bank. One is a 2-bit field whose target is chosen by a mode bit. The last holds the mode bit.

Reads from the fixed ROM window, the switchable ROM window and the RAM window are translated into physical ROM and RAM addresses. The block asserts the matching chip select and returns the selected memory's byte on the bus. Both memories are assumed to answer combinationally in the same cycle. ROM and RAM sizes are power-of-two parameters. An address past the end of a memory wraps by dropping its upper bits.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the low bank field, the upper ROM-bank bits, the RAM bank, the mode bit and the RAM enable are all zero. A read at 0x4000 therefore addresses physical ROM 0x4000, and a RAM-window read returns 0x00 without a chip select.
- R2: A read in 0x0000–0x3FFF drives rom_addr equal to the bus address, zero-extended, and asserts rom_cs. bus_rdata returns rom_rdata.
- R3: A read in 0x4000–0x7FFF drives rom_addr = (effective bank × 0x4000 + address[13:0]), keeping only the low ROM_AW bits, so that banks past the ROM size wrap.
- R4: A write in 0x0000–0x1FFF enables RAM when data[3:0] is 0xA. Any other data disables RAM.
- R5: A write in 0x2000–0x3FFF loads data[4:0] into the low bank field and leaves the upper ROM-bank bits unchanged.
- R6: A write in 0x4000–0x5FFF loads data[1:0] into the upper ROM-bank bits (bank bits 6:5) when the mode bit is 0, and into the RAM bank when it is 1. The other target keeps its value.
- R7: A write in 0x6000–0x7FFF with data 0x00 clears the mode bit, and with data 0x01 sets it. Any other data leaves the mode bit unchanged.
- R8: When the low bank field is zero, the effective bank is the 7-bit bank value plus one. Bank 0 becomes 1, and 0x20, 0x40 and 0x60 become 0x21, 0x41 and 0x61.
- R9: With RAM enabled, an access in 0xA000–0xBFFF drives ram_addr = (RAM bank × 0x2000 + address[12:0]), keeping only the low RAM_AW bits, and asserts ram_cs. A write also asserts ram_we with ram_wdata equal to the bus data. A read returns ram_rdata.
- R10: With RAM disabled, a RAM-window read returns 0x00, and ram_cs and ram_we stay low for both reads and writes.
- R11: Accesses outside the ROM and RAM windows return 0x00 with no chip select. A write never asserts rom_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_rdata | output | 8 | Read data returned to the CPU |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select (reads only) |
| rom_rdata | input | 8 | ROM data |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data |

## Verification
The assertions cover the register-update rules on every cycle. These are that a low-bank write keeps the upper bits, that a secondary write with mode set leaves the ROM bits alone, that invalid mode data is ignored, and that enable decodes only the low nibble. They also check every cycle that RAM strobes never appear while RAM is disabled, that ROM is never selected on a write, and that fixed-window reads carry no bank bits. The arithmetic of the effective bank is shown only by the bench's scenarios. This covers the zero-to-one remap, the carry into 0x21, 0x41 and 0x61, and the wrap when the ROM and RAM are smaller than the bank fields can reach. The bench also reads back bytes written to RAM in different banks.

// File: rtl/cart_bank_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register-select encoding and the control state
// record for the cartridge bank controller.
// Assumes the bus address is 16 bits and the data 8 bits.
package cart_bank_pkg;

    localparam int BUS_AW   = 16;
    localparam int BUS_DW   = 8;
    localparam int LO_W     = 5;               // low ROM bank field
    localparam int HI_W     = 2;               // secondary field width
    localparam int BANK_W   = LO_W + HI_W;     // full ROM bank number
    localparam int ROM_PG_W = 14;              // 16 KiB ROM page
    localparam int RAM_PG_W = 13;              // 8 KiB RAM page

    // Register targeted by a write to ROM space, decoded from address[14:13].
    typedef enum logic [1:0] {
        SEL_RAM_EN = 2'd0,
        SEL_LO     = 2'd1,
        SEL_SEC    = 2'd2,
        SEL_MODE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              ram_on;
        logic              mode;
        logic [LO_W-1:0]   lo_bank;
        logic [HI_W-1:0]   hi_bank;
        logic [HI_W-1:0]   ram_bank;
    } ctrl_state_t;

endpackage

// File: rtl/cbc_ctrl_regs.sv
`timescale 1ns/1ps
// Module: cbc_ctrl_regs
// Holds the bank control registers and updates them on CPU writes into
// ROM space. Assumes wr_en is already qualified by the ROM-space decode.
module cbc_ctrl_regs
    import cart_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [BUS_DW-1:0] wdata,
    output ctrl_state_t       st
);

    // Register update: one target per write, chosen by the select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_RAM_EN: st.ram_on  <= (wdata[3:0] == 4'hA);
                SEL_LO:     st.lo_bank <= wdata[LO_W-1:0];
                SEL_SEC: begin
                    if (st.mode) st.ram_bank <= wdata[HI_W-1:0];
                    else         st.hi_bank  <= wdata[HI_W-1:0];
                end
                SEL_MODE: begin
                    if (wdata == 8'h00)      st.mode <= 1'b0;
                    else if (wdata == 8'h01) st.mode <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_EN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RAM_EN) |=> (st.ram_on == ($past(wdata[3:0]) == 4'hA))); // R4
    AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LO) |=> (st.lo_bank == $past(wdata[LO_W-1:0]))); // R5
    AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LO) |=> $stable(st.hi_bank)); // R5
    AST_SEC_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SEC && st.mode) |=> $stable(st.hi_bank)); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_MODE && wdata > 8'h01) |=> $stable(st.mode)); // R7

endmodule

// File: rtl/cbc_rom_xlat.sv
`timescale 1ns/1ps
// Module: cbc_rom_xlat
// Turns a ROM-space bus address and the bank registers into a physical ROM
// address. Bank 0 is fixed below 0x4000; above it the effective bank is used.
// Assumes ROM_AW >= 15 (at least two pages); truncation is the size mask.
module cbc_rom_xlat
    import cart_bank_pkg::*;
#(
    parameter int ROM_AW = 21
) (
    input  logic [ROM_PG_W:0]   cpu_off,   // bit 14 selects the switchable page
    input  logic [LO_W-1:0]     lo_bank,
    input  logic [HI_W-1:0]     hi_bank,
    output logic [ROM_AW-1:0]   rom_addr
);

    localparam int FULL_W = BANK_W + ROM_PG_W;

    logic [BANK_W-1:0] eff_bank;
    logic [FULL_W-1:0] full_addr;

    // Effective bank: a zero low field advances the whole bank by one.
    always_comb begin
        eff_bank = {hi_bank, lo_bank} + BANK_W'(lo_bank == '0);
    end

    // Physical address before size masking.
    always_comb begin
        if (cpu_off[ROM_PG_W]) full_addr = {eff_bank, cpu_off[ROM_PG_W-1:0]};
        else                   full_addr = {{BANK_W{1'b0}}, cpu_off[ROM_PG_W-1:0]};
    end

    generate
        if (ROM_AW <= FULL_W) begin : g_trunc
            assign rom_addr = full_addr[ROM_AW-1:0];
        end else begin : g_extend
            assign rom_addr = {{(ROM_AW-FULL_W){1'b0}}, full_addr};
        end
    endgenerate

endmodule

// File: rtl/cbc_ram_xlat.sv
`timescale 1ns/1ps
// Module: cbc_ram_xlat
// Maps an offset in the RAM window and the RAM bank onto a physical RAM
// address. Assumes RAM_AW >= 13; truncation is the size mask.
module cbc_ram_xlat
    import cart_bank_pkg::*;
#(
    parameter int RAM_AW = 15
) (
    input  logic [RAM_PG_W-1:0] cpu_off,
    input  logic [HI_W-1:0]     ram_bank,
    output logic [RAM_AW-1:0]   ram_addr
);

    localparam int FULL_W = HI_W + RAM_PG_W;

    logic [FULL_W-1:0] full_addr;

    // Bank concatenated above the page offset.
    always_comb full_addr = {ram_bank, cpu_off};

    generate
        if (RAM_AW <= FULL_W) begin : g_trunc
            assign ram_addr = full_addr[RAM_AW-1:0];
        end else begin : g_extend
            assign ram_addr = {{(RAM_AW-FULL_W){1'b0}}, full_addr};
        end
    endgenerate

endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
// Module: cart_bank_ctrl (top)
// Decodes the CPU bus into register writes, ROM reads and RAM accesses,
// drives the physical addresses and chip selects, and muxes read data.
// Assumes both memories answer combinationally and sizes are powers of two.
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_AW = 21,
    parameter int RAM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs,
    input  logic [7:0]        rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);

    ctrl_state_t st;
    logic        in_rom;
    logic        in_ram;
    logic        rd_only;
    reg_sel_e    sel;

    // Window decode.
    always_comb begin
        in_rom  = ~bus_addr[15];
        in_ram  = (bus_addr[15:13] == 3'b101);
        rd_only = bus_rd & ~bus_wr;
        sel     = reg_sel_e'(bus_addr[14:13]);
    end

    cbc_ctrl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr & in_rom),
        .sel   (sel),
        .wdata (bus_wdata),
        .st    (st)
    );

    cbc_rom_xlat #(.ROM_AW(ROM_AW)) u_rom_xlat (
        .cpu_off  (bus_addr[ROM_PG_W:0]),
        .lo_bank  (st.lo_bank),
        .hi_bank  (st.hi_bank),
        .rom_addr (rom_addr)
    );

    cbc_ram_xlat #(.RAM_AW(RAM_AW)) u_ram_xlat (
        .cpu_off  (bus_addr[RAM_PG_W-1:0]),
        .ram_bank (st.ram_bank),
        .ram_addr (ram_addr)
    );

    // Chip selects and write strobe.
    always_comb begin
        rom_cs    = rd_only & in_rom;
        ram_cs    = (rd_only | bus_wr) & in_ram & st.ram_on;
        ram_we    = bus_wr & in_ram & st.ram_on;
        ram_wdata = bus_wdata;
    end

    // Read data mux; anything unselected returns zero.
    always_comb begin
        if (rom_cs)                 bus_rdata = rom_rdata;
        else if (ram_cs && rd_only) bus_rdata = ram_rdata;
        else                        bus_rdata = 8'h00;
    end

    AST_RAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs || ram_we) |-> st.ram_on); // R10
    AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !rom_cs); // R11
    AST_FIXED_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs && !bus_addr[14]) |-> ((rom_addr >> ROM_PG_W) == '0)); // R2
    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_ram && !st.ram_on) |-> (bus_rdata == 8'h00)); // R10

endmodule

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;

    localparam int ROM_AW = 20;   // 64 pages: bank 0x41 wraps to 0x01
    localparam int RAM_AW = 14;   // 2 RAM pages: bank 2 wraps to 0

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_rdata;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_cs;
    logic [7:0]        rom_rdata;
    logic [RAM_AW-1:0] ram_addr;
    logic              ram_cs;
    logic              ram_we;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] ram_mem [0:127];

    always #5 clk = ~clk;

    cart_bank_ctrl #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] a);
        return a[7:0] ^ {2'b00, a[19:14]};
    endfunction

    assign rom_rdata = rom_byte(rom_addr);
    assign ram_rdata = ram_mem[{ram_addr[13], ram_addr[5:0]}];

    always @(posedge clk) if (ram_we) ram_mem[{ram_addr[13], ram_addr[5:0]}] <= ram_wdata;

    // Captured outputs.
    logic [7:0]        s_rdata;
    logic [ROM_AW-1:0] s_rom_addr;
    logic [RAM_AW-1:0] s_ram_addr;
    logic              s_rom_cs, s_ram_cs, s_ram_we;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic capture();
        s_rdata = bus_rdata; s_rom_addr = rom_addr; s_ram_addr = ram_addr;
        s_rom_cs = rom_cs; s_ram_cs = ram_cs; s_ram_we = ram_we;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #2 capture();
        #1 bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        #2 capture();
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rom_read_chk(input string req, input logic [15:0] a, input logic [ROM_AW-1:0] exp);
        rd(a);
        chk(req, s_rom_addr, exp);
        chk(req, s_rom_cs, 1'b1);
        chk(req, s_rdata, rom_byte(exp));
    endtask

    task automatic t_reset();
        rom_read_chk("R1", 16'h4000, 20'h04000);
        rd(16'hA000);
        chk("R1", s_rdata, 8'h00);
        chk("R1", s_ram_cs, 1'b0);
    endtask

    task automatic t_fixed();
        rom_read_chk("R2", 16'h0000, 20'h00000);
        rom_read_chk("R2", 16'h3FFF, 20'h03FFF);
        wr(16'h2000, 8'h05);
        rom_read_chk("R2", 16'h1234, 20'h01234);
    endtask

    task automatic t_low_bank();
        rom_read_chk("R3", 16'h4ABC, 20'h14ABC);
        wr(16'h3FFF, 8'hE7);                        // R5: only bits [4:0] used
        rom_read_chk("R5", 16'h7FFF, 20'h1FFFF);
    endtask

    task automatic t_remap();
        wr(16'h2000, 8'h00);
        rom_read_chk("R8", 16'h4010, 20'h04010);    // 0 -> 1
        wr(16'h4000, 8'h01);
        rom_read_chk("R8", 16'h4010, 20'h84010);    // 0x20 -> 0x21
        wr(16'h4000, 8'h03);
        rom_read_chk("R3", 16'h4010, 20'h84010);    // 0x61 wraps to 0x21
        wr(16'h4000, 8'h02);
        rom_read_chk("R3", 16'h4010, 20'h04010);    // 0x41 wraps to 0x01
    endtask

    task automatic t_keep_hi();
        wr(16'h4000, 8'h01);
        wr(16'h2000, 8'h1F);
        rom_read_chk("R5", 16'h4000, 20'hFC000);
        wr(16'h2000, 8'h03);
        rom_read_chk("R5", 16'h4000, 20'h8C000);
    endtask

    task automatic t_mode();
        wr(16'h6000, 8'h01);
        wr(16'h4000, 8'h03);                        // to RAM bank
        rom_read_chk("R6", 16'h4000, 20'h8C000);
        wr(16'h6000, 8'h02);                        // ignored, mode stays 1
        wr(16'h4000, 8'h00);
        rom_read_chk("R7", 16'h4000, 20'h8C000);
        wr(16'h6000, 8'h00);
        wr(16'h4000, 8'h00);                        // to ROM bits 6:5
        rom_read_chk("R6", 16'h4000, 20'h0C000);
        wr(16'h6000, 8'h01);
        wr(16'h6000, 8'hFF);                        // ignored
        wr(16'h4000, 8'h00);                        // RAM bank 0
        rom_read_chk("R7", 16'h4000, 20'h0C000);
    endtask

    task automatic t_ram();
        wr(16'h0000, 8'h1A);                        // R4: only low nibble
        wr(16'hA005, 8'h77);
        chk("R9", s_ram_we, 1'b1);
        chk("R9", s_ram_addr, 14'h0005);
        wr(16'h4000, 8'h01);
        wr(16'hA005, 8'h88);
        chk("R9", s_ram_addr, 14'h2005);
        rd(16'hA005);
        chk("R9", s_rdata, 8'h88);
        chk("R9", s_ram_cs, 1'b1);
        wr(16'h4000, 8'h00);
        rd(16'hA005);
        chk("R9", s_rdata, 8'h77);
        wr(16'h4000, 8'h02);                        // wraps to page 0
        rd(16'hA005);
        chk("R9", s_ram_addr, 14'h0005);
        chk("R9", s_rdata, 8'h77);
        wr(16'h4000, 8'h03);
        rd(16'hA005);
        chk("R9", s_rdata, 8'h88);
    endtask

    task automatic t_disabled();
        wr(16'h0000, 8'h0B);
        rd(16'hA005);
        chk("R4", s_rdata, 8'h00);
        chk("R10", s_ram_cs, 1'b0);
        wr(16'hA005, 8'h55);
        chk("R10", s_ram_we, 1'b0);
        wr(16'h1FFF, 8'h3A);
        rd(16'hA005);
        chk("R10", s_rdata, 8'h88);
    endtask

    task automatic t_outside();
        rd(16'h8000);
        chk("R11", s_rdata, 8'h00);
        chk("R11", {s_rom_cs, s_ram_cs}, 2'b00);
        rd(16'hC000);
        chk("R11", s_rdata, 8'h00);
        chk("R11", {s_rom_cs, s_ram_cs}, 2'b00);
        wr(16'h2000, 8'h02);
        chk("R11", s_rom_cs, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) ram_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_low_bank();
        t_remap();
        t_keep_hi();
        t_mode();
        t_ram();
        t_disabled();
        t_outside();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule